// File: doc/BRIEF.md
# Timer Count-Source Selector with Edge-Triggered Clear

This block is the counting core of a general-purpose timer. It holds a prescale counter and a timer counter. An 8-bit control value chooses what drives them. The prescaler can advance on every system-clock cycle. It can instead advance on rising, falling or both edges of one of four external capture pins, and those pins are sampled by the system clock. When the prescale counter reaches the programmed prescale value, it returns to zero and the timer counter steps by one.

A second field of the control value can arm a synchronous clear. A chosen edge of capture pin 0, 1 or 2 then zeroes both counters. Two plain write strobes load the control value and the prescale value. A run-enable pin gates counting, and a hold-clear pin keeps both counters at zero. There is no data stream through the block. Every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. The counter values are presented continuously.

Top module: `tcc_core`

## Requirements
- R1: After reset the control value and prescale value are 0, both counters read 0, and timer mode is active, so with run enabled the timer counter advances once per cycle.
- R2: In timer mode (control bits 1:0 = 0) the prescaler advances on every clock edge while run is enabled. When it equals the prescale value it returns to 0 and the timer counter increments. After N cycles the timer counter is N/(P+1) and the prescaler is N mod (P+1).
- R3: Control bits 1:0 = 1, 2 or 3 make each rising, falling or either edge of the selected capture pin one prescaler tick.
- R4: Control bits 3:2 pick capture pin 0 to 3 as the count source. Edges on the other pins do not change the counters.
- R5: A capture pin is synchronised by two flops and compared with a third copy. A level change first sampled at clock edge k shows in the counters after edge k+2 and not before.
- R6: With control bit 4 set, the edge coded in bits 7:5 zeroes both counters. The codes are: 0 for the rise of pin 0 and 1 for its fall, 2 for the rise of pin 1 and 3 for its fall, 4 for the rise of pin 2 and 5 for its fall. With bit 4 clear, no clear occurs.
- R7: Clear codes 6 and 7 never clear the counters.
- R8: When a clear event and a count tick fall in the same cycle, both counters are 0 afterwards.
- R9: With run_en low, count ticks leave both counters unchanged.
- R10: While hold_clr is high, both counters are held at 0. This takes priority over every other event.
- R11: The timer counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Loads ctl_wdata into the control value |
| ctl_wdata | input | 8 | Control value: [1:0] source mode, [3:2] count pin, [4] clear arm, [7:5] clear code |
| ps_we | input | 1 | Loads ps_wdata into the prescale value |
| ps_wdata | input | PS_W | New prescale value |
| run_en | input | 1 | Counting enable |
| hold_clr | input | 1 | Holds both counters at zero while high |
| cap_in | input | 4 | Asynchronous capture pins |
| tc_out | output | CNT_W | Timer counter |
| pc_out | output | PS_W | Prescale counter |

## Verification
Some properties are checked on every cycle by the assertions. Hold-clear zeroes the counters, and a clear event beats a same-cycle tick. Counters stay frozen when no tick is allowed, and a prescaler match carries into the timer counter with wrap-around. Reserved or disarmed clear codes never fire, and one pin change yields only a single-cycle edge pulse. Other behaviours need the bench's scenarios to show them. These are the exact counts for each mode and pin pairing, the immunity to the unselected pins, the two-edge input latency, and the full clear-code sweep against both edge directions.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CAP_N = 4;
  localparam int SEL_W = 2;
  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } src_mode_e;

  // Packed from MSB: [7:5] clear code, [4] clear arm, [3:2] pin select, [1:0] mode
  typedef struct packed {
    logic [2:0]       clr_code;
    logic             clr_en;
    logic [SEL_W-1:0] in_sel;
    src_mode_e        mode;
  } ctl_t;

  localparam logic [2:0] CLR_CODE_LIMIT = 3'd6;
endpackage

// File: rtl/tcc_pin_edge.sv
module tcc_pin_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic m1, m2, m3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= 1'b0;
        m2 <= 1'b0;
        m3 <= 1'b0;
      end else begin
        m1 <= pin[i];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign rise[i] = m2 & ~m3;
    assign fall[i] = ~m2 & m3;

    // R3: one pin change gives a single-cycle pulse
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]);
  end
endmodule

// File: rtl/tcc_src_decode.sv
module tcc_src_decode
  import tcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [CAP_N-1:0] rise,
  input  logic [CAP_N-1:0] fall,
  output logic             tick,
  output logic             clr_evt
);
  logic [SEL_W-1:0] clr_pin;
  logic             clr_edge;
  logic             code_ok;

  always_comb begin
    unique case (ctl.mode)
      SRC_CLK:  tick = 1'b1;
      SRC_RISE: tick = rise[ctl.in_sel];
      SRC_FALL: tick = fall[ctl.in_sel];
      default:  tick = rise[ctl.in_sel] | fall[ctl.in_sel];
    endcase
  end

  always_comb begin
    clr_pin  = ctl.clr_code[2:1];
    code_ok  = ctl.clr_code < CLR_CODE_LIMIT;
    clr_edge = ctl.clr_code[0] ? fall[clr_pin] : rise[clr_pin];
    clr_evt  = ctl.clr_en & code_ok & clr_edge;
  end

  assert_timer_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == SRC_CLK) |-> tick);
  assert_clr_disarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.clr_en |-> !clr_evt);
  assert_clr_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clr_code >= CLR_CODE_LIMIT) |-> !clr_evt);
endmodule

// File: rtl/tcc_count.sv
module tcc_count #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             hold,
  input  logic             clr,
  input  logic             tick,
  input  logic [PS_W-1:0]  ps_lim,
  output logic [CNT_W-1:0] tc,
  output logic [PS_W-1:0]  pc
);
  localparam logic [CNT_W-1:0] TC_ONE = CNT_W'(1);
  localparam logic [PS_W-1:0]  PC_ONE = PS_W'(1);

  logic adv;
  assign adv = run_en & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0;
      pc <= '0;
    end else if (hold || clr) begin
      tc <= '0;
      pc <= '0;
    end else if (adv) begin
      if (pc == ps_lim) begin
        pc <= '0;
        tc <= tc + TC_ONE;
      end else begin
        pc <= pc + PC_ONE;
      end
    end
  end

  assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc == '0) && (pc == '0));
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hold) |=> (tc == '0) && (pc == '0));
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clr && !(run_en && tick)) |=> $stable(tc) && $stable(pc));
  assert_carry_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clr && run_en && tick && pc == ps_lim) |=>
      (pc == '0) && (tc == $past(tc) + TC_ONE));
endmodule

// File: rtl/tcc_core.sv
module tcc_core
  import tcc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ps_we,
  input  logic [PS_W-1:0]  ps_wdata,
  input  logic             run_en,
  input  logic             hold_clr,
  input  logic [CAP_N-1:0] cap_in,
  output logic [CNT_W-1:0] tc_out,
  output logic [PS_W-1:0]  pc_out
);
  logic [CTL_W-1:0] ctl_q;
  logic [PS_W-1:0]  ps_q;
  ctl_t             ctl_s;
  logic [CAP_N-1:0] rise, fall;
  logic             tick, clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ps_q  <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (ps_we)  ps_q  <= ps_wdata;
    end
  end

  assign ctl_s = ctl_t'(ctl_q);

  tcc_pin_edge #(.N(CAP_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(rise), .fall(fall)
  );

  tcc_src_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_s), .rise(rise), .fall(fall),
    .tick(tick), .clr_evt(clr_evt)
  );

  tcc_count #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold(hold_clr),
    .clr(clr_evt), .tick(tick), .ps_lim(ps_q), .tc(tc_out), .pc(pc_out)
  );

  assert_ctl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_q == $past(ctl_wdata));
endmodule

// File: tb/tcc_core_bench.sv
`timescale 1ns/1ps
module tcc_core_bench;
  localparam int CW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic          ps_we = 1'b0;
  logic [PW-1:0] ps_wdata = '0;
  logic          run_en = 1'b0;
  logic          hold_clr = 1'b0;
  logic [3:0]    cap_in = '0;
  logic [CW-1:0] tc_out;
  logic [PW-1:0] pc_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tcc_core #(.CNT_W(CW), .PS_W(PW)) u_tcc_core (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ps_we(ps_we), .ps_wdata(ps_wdata), .run_en(run_en), .hold_clr(hold_clr),
    .cap_in(cap_in), .tc_out(tc_out), .pc_out(pc_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; step(1); ctl_we = 1'b0;
  endtask

  task automatic wr_ps(input int v);
    ps_we = 1'b1; ps_wdata = PW'(v); step(1); ps_we = 1'b0;
  endtask

  task automatic zero();
    hold_clr = 1'b1; step(1); hold_clr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    cap_in = cap_in | m; step(4);
    cap_in = cap_in & ~m; step(4);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: reset values and default timer mode
    chk("R1 tc after reset", int'(tc_out), 0);
    chk("R1 pc after reset", int'(pc_out), 0);
    run_en = 1'b1; step(3); run_en = 1'b0;
    chk("R1 default timer mode", int'(tc_out), 3);

    // R2: timer mode across prescale values
    for (int p = 0; p < 4; p++) begin
      wr_ps(p); wr_ctl(8'h00); zero();
      run_en = 1'b1; step(12); run_en = 1'b0;
      chk("R2 timer tc", int'(tc_out), 12 / (p + 1));
      chk("R2 timer pc", int'(pc_out), 12 % (p + 1));
    end

    // R3, R4: every edge mode on every pin, with noise on the other pins
    for (int m = 1; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [3:0] own, oth;
        int e;
        own = 4'b1 << s;
        oth = ~own;
        wr_ps(1); wr_ctl({4'b0000, 2'(s), 2'(m)}); zero();
        run_en = 1'b1;
        pulse(oth); pulse(oth);
        chk("R4 other pins ignored", int'(tc_out) * 16 + int'(pc_out), 0);
        pulse(own); pulse(own); pulse(own);
        run_en = 1'b0;
        e = (m == 3) ? 6 : 3;
        chk("R3 edge count tc", int'(tc_out), e / 2);
        chk("R3 edge count pc", int'(pc_out), e % 2);
      end
    end

    // R5: latency of two edges after first sampling edge
    wr_ps(0); wr_ctl(8'h01); zero();
    run_en = 1'b1;
    cap_in[0] = 1'b1; step(2);
    chk("R5 not yet counted", int'(tc_out), 0);
    step(1);
    chk("R5 counted on third edge", int'(tc_out), 1);
    cap_in[0] = 1'b0; step(4); run_en = 1'b0;

    // R6, R7: sweep of clear codes, plus a disarmed case (index 8)
    for (int c = 0; c < 9; c++) begin
      logic en;
      logic [2:0] code;
      int cr, cf;
      en   = (c < 8);
      code = 3'(c % 8);
      wr_ps(3); wr_ctl({code, en, 2'b00, 2'b00}); zero();
      run_en = 1'b1; step(20);
      cap_in = 4'hF; step(11);
      cr = (en && code < 6 && code[0] == 1'b0) ? 8 : 31;
      chk(c < 6 ? "R6 rise phase" : "R7 rise phase",
          int'(tc_out) * 16 + int'(pc_out), (cr / 4) * 16 + cr % 4);
      cap_in = 4'h0; step(11);
      cf = (en && code < 6 && code[0] == 1'b1) ? 8 : cr + 11;
      chk(c < 6 ? "R6 fall phase" : "R7 fall phase",
          int'(tc_out) * 16 + int'(pc_out), (cf / 4) * 16 + cf % 4);
      run_en = 1'b0;
    end

    // R8: clear and count in the same cycle
    wr_ps(0); wr_ctl(8'h21); zero();
    run_en = 1'b1;
    pulse(4'b0001);
    chk("R8 prior count", int'(tc_out), 1);
    wr_ctl(8'h11);
    pulse(4'b0001);
    chk("R8 clear wins", int'(tc_out) * 16 + int'(pc_out), 0);
    run_en = 1'b0;

    // R9: run gate
    wr_ps(0); wr_ctl(8'h00); zero();
    run_en = 1'b1; step(5); run_en = 1'b0; step(10);
    chk("R9 timer frozen", int'(tc_out), 5);
    wr_ctl(8'h03); pulse(4'b0001);
    chk("R9 edges ignored", int'(tc_out) * 16 + int'(pc_out), 5 * 16);

    // R10: hold clear
    wr_ctl(8'h00); run_en = 1'b1;
    hold_clr = 1'b1; step(6);
    chk("R10 held at zero", int'(tc_out) * 16 + int'(pc_out), 0);
    hold_clr = 1'b0; step(3);
    chk("R10 resumes", int'(tc_out), 3);
    run_en = 1'b0;

    // R11: wrap of the timer counter
    zero(); run_en = 1'b1; step(260); run_en = 1'b0;
    chk("R11 wrap", int'(tc_out), 260 % 256);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule